// File: doc/BRIEF.md
# Card Window Decoder with Strobe Timing

This block sits between a host bus and a pair of removable-card sockets. It holds eight programmable address windows. Each window has a base register and an option register. Every host request is compared against all enabled windows at once. The lowest-numbered matching window selects the target socket, the address space (common memory, attribute memory or I/O), the port width and the card-side offset.

On a hit, the block runs a card access in three timed phases: address setup, strobe and hold. The length of each phase comes from cycle counts stored in the matching window's option register. The window size is programmed as a non-linear 5-bit code. Some code values are reserved, and a window using one never matches. Writes that land in a write-protected window are refused: no strobe is started and a one-cycle error pulse is raised. Windows whose three phases together reach the bus-monitor limit are never matched, so no access can outlast it.

Software programs the windows through a simple word-indexed register port. The host side offers one request at a time. A request is taken only while the sequencer is idle.

Top module: `cwin_decoder`

## Requirements
- R1: After reset, every window register reads zero, and busy_o, setup_o, strobe_o, hold_o, done_o and wp_err_o are low.
- R2: Register word 2n is the base of window n and word 2n+1 its option; a write becomes visible to reads on the next cycle. Option bits 5 and 26..20 are reserved and read as zero. Option fields: bit 0 valid, bit 1 write-protect, bit 2 socket, bits 4:3 space (00 common, 10 attribute, 11 I/O), bit 6 16-bit port, bits 11:7 strobe count, bits 15:12 setup count, bits 19:16 hold count, bits 31:27 size code.
- R3: Size code to log2(bytes): 0→0, 1→1, 2→3, 3→2, 4→7, 5→6, 6→4, 7→5, 8→15, 9→14, 10→12, 11→13, 12→8, 13→9, 14→11, 15→10, 20→24, 21→25, 23→26, 24→16, 25→17, 26→19, 27→18, 28→23, 29→22, 30→20, 31→21. Codes 16..19 and 22 are reserved, and a window using one never hits.
- R4: A window hits when it is valid and the address and base agree in every bit above log2(size). The card offset is the address bits below log2(size). An invalid window never hits.
- R5: When several windows hit, the lowest-numbered one is used.
- R6: For any space other than I/O, base bits 11:0 are treated as zero when matching.
- R7: An I/O window with a size above 64 KB never hits.
- R8: An accepted access shows setup_o for the setup count, then strobe_o for the strobe count, then hold_o for the hold count. The first phase starts on the cycle after acceptance. A zero count skips that phase. done_o pulses for one cycle after the last phase, and busy_o is high exactly while a phase is shown.
- R9: An accepted access whose three counts are all zero raises done_o on the next cycle without showing any phase.
- R10: A write that hits a write-protected window starts no phase and pulses wp_err_o for one cycle. A read of the same window proceeds normally.
- R11: A window whose setup+strobe+hold is 60 or more never hits. A total of 59 gives a 59-cycle access.
- R12: While busy_o is high, win_o, sock_o, space_o and wide_o hold the values of the accepted window. Requests made while busy are dropped.
- R13: A request that hits no window is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 4 | Register word index (2n base, 2n+1 option) |
| cfg_wdata_i | input | 32 | Register write data |
| cfg_rdata_o | output | 32 | Register read data at cfg_addr_i |
| req_i | input | 1 | Host access request |
| req_write_i | input | 1 | Request is a write |
| req_addr_i | input | 32 | Host address |
| busy_o | output | 1 | Access in progress |
| win_o | output | 3 | Index of the window being served |
| sock_o | output | 1 | Target socket (0 = first, 1 = second) |
| space_o | output | 2 | Space: 00 common, 10 attribute, 11 I/O |
| wide_o | output | 1 | 16-bit port |
| card_off_o | output | 32 | Offset within the window |
| setup_o | output | 1 | Setup phase |
| strobe_o | output | 1 | Strobe phase |
| hold_o | output | 1 | Hold phase |
| done_o | output | 1 | One-cycle pulse at the end of an access |
| wp_err_o | output | 1 | One-cycle write-protect refusal |

## Verification
A wrong phase counter or a wrong phase state shows at the strobe pins on the very cycle it goes wrong. A phase that is too long or too short, or missing, or in the wrong order, is seen at once against the cycle model. A bad size decode or a bad priority choice shows one cycle after the request: the access starts or fails to start, or win_o and card_off_o carry the wrong values. Corrupted latched attributes show on sock_o, space_o and wide_o on any cycle of the access.

// File: rtl/cwin_pkg.sv
package cwin_pkg;

  localparam int OPT_VALID = 0;
  localparam int OPT_WP    = 1;
  localparam int OPT_SOCK  = 2;
  localparam int OPT_SPC   = 3;
  localparam int OPT_WIDE  = 6;
  localparam int STB_LO    = 7;
  localparam int STB_W     = 5;
  localparam int SU_LO     = 12;
  localparam int SU_W      = 4;
  localparam int HO_LO     = 16;
  localparam int HO_W      = 4;
  localparam int SZ_LO     = 27;
  localparam int SZ_W      = 5;

  typedef enum logic [1:0] {
    SPC_COMMON = 2'b00,
    SPC_RSVD   = 2'b01,
    SPC_ATTR   = 2'b10,
    SPC_IO     = 2'b11
  } space_e;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_HOLD   = 2'd3
  } phase_e;

  typedef struct packed {
    logic            ok;
    logic [4:0]      lg;
  } size_t;

  typedef struct packed {
    logic [SZ_W-1:0]  size_code;
    logic [HO_W-1:0]  hold;
    logic [SU_W-1:0]  setup;
    logic [STB_W-1:0] strobe;
    logic             wide;
    space_e           space;
    logic             sock;
    logic             wp;
    logic             valid;
  } opt_t;

  function automatic opt_t opt_unpack(input logic [31:0] w);
    opt_t o;
    o.size_code = w[SZ_LO +: SZ_W];
    o.hold      = w[HO_LO +: HO_W];
    o.setup     = w[SU_LO +: SU_W];
    o.strobe    = w[STB_LO +: STB_W];
    o.wide      = w[OPT_WIDE];
    o.space     = space_e'(w[OPT_SPC +: 2]);
    o.sock      = w[OPT_SOCK];
    o.wp        = w[OPT_WP];
    o.valid     = w[OPT_VALID];
    return o;
  endfunction

  function automatic logic [31:0] opt_pack(input opt_t o);
    logic [31:0] w;
    w = '0;
    w[SZ_LO +: SZ_W]   = o.size_code;
    w[HO_LO +: HO_W]   = o.hold;
    w[SU_LO +: SU_W]   = o.setup;
    w[STB_LO +: STB_W] = o.strobe;
    w[OPT_WIDE]        = o.wide;
    w[OPT_SPC +: 2]    = o.space;
    w[OPT_SOCK]        = o.sock;
    w[OPT_WP]          = o.wp;
    w[OPT_VALID]       = o.valid;
    return w;
  endfunction

  // non-linear size code -> log2 of window bytes
  function automatic size_t size_decode(input logic [SZ_W-1:0] code);
    size_t s;
    s.ok = 1'b1;
    unique case (code)
      5'd0:  s.lg = 5'd0;
      5'd1:  s.lg = 5'd1;
      5'd2:  s.lg = 5'd3;
      5'd3:  s.lg = 5'd2;
      5'd4:  s.lg = 5'd7;
      5'd5:  s.lg = 5'd6;
      5'd6:  s.lg = 5'd4;
      5'd7:  s.lg = 5'd5;
      5'd8:  s.lg = 5'd15;
      5'd9:  s.lg = 5'd14;
      5'd10: s.lg = 5'd12;
      5'd11: s.lg = 5'd13;
      5'd12: s.lg = 5'd8;
      5'd13: s.lg = 5'd9;
      5'd14: s.lg = 5'd11;
      5'd15: s.lg = 5'd10;
      5'd20: s.lg = 5'd24;
      5'd21: s.lg = 5'd25;
      5'd23: s.lg = 5'd26;
      5'd24: s.lg = 5'd16;
      5'd25: s.lg = 5'd17;
      5'd26: s.lg = 5'd19;
      5'd27: s.lg = 5'd18;
      5'd28: s.lg = 5'd23;
      5'd29: s.lg = 5'd22;
      5'd30: s.lg = 5'd20;
      5'd31: s.lg = 5'd21;
      default: begin
        s.ok = 1'b0;
        s.lg = 5'd0;
      end
    endcase
    return s;
  endfunction

endpackage

// File: rtl/cwin_regs.sv
module cwin_regs
  import cwin_pkg::*;
#(
  parameter int N_WIN = 8,
  parameter int IDX_W = $clog2(2 * N_WIN)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [IDX_W-1:0]       addr_i,
  input  logic [31:0]            wdata_i,
  output logic [31:0]            rdata_o,
  output logic [N_WIN-1:0][31:0] base_o,
  output opt_t [N_WIN-1:0]       opt_o
);

  localparam int WIN_W = IDX_W - 1;

  for (genvar w = 0; w < N_WIN; w++) begin : g_win
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_o[w] <= '0;
        opt_o[w]  <= '0;
      end else if (we_i && addr_i[IDX_W-1:1] == WIN_W'(w)) begin
        if (addr_i[0]) opt_o[w]  <= opt_unpack(wdata_i);
        else           base_o[w] <= wdata_i;
      end
    end
  end

  always_comb begin
    if (addr_i[0]) rdata_o = opt_pack(opt_o[addr_i[IDX_W-1:1]]);
    else           rdata_o = base_o[addr_i[IDX_W-1:1]];
  end

endmodule

// File: rtl/cwin_match.sv
module cwin_match
  import cwin_pkg::*;
#(
  parameter int N_WIN     = 8,
  parameter int ADDR_W    = 32,
  parameter int BUS_LIMIT = 60,
  parameter int IO_MAX_LG = 16,
  parameter int WIN_W     = $clog2(N_WIN)
) (
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [N_WIN-1:0][31:0] base_i,
  input  opt_t [N_WIN-1:0]       opt_i,
  output logic                   hit_o,
  output logic [WIN_W-1:0]       idx_o,
  output logic                   wp_o,
  output logic                   sock_o,
  output space_e                 space_o,
  output logic                   wide_o,
  output logic [SU_W-1:0]        su_o,
  output logic [STB_W-1:0]       st_o,
  output logic [HO_W-1:0]        ho_o,
  output logic [ADDR_W-1:0]      off_o
);

  localparam int TOT_W = $clog2((1 << SU_W) + (1 << STB_W) + (1 << HO_W));
  localparam logic [ADDR_W-1:0] PAGE_MASK = {{(ADDR_W-12){1'b1}}, 12'h000};

  logic [N_WIN-1:0]             hit_vec;
  logic [N_WIN-1:0][ADDR_W-1:0] off_vec;

  for (genvar w = 0; w < N_WIN; w++) begin : g_cmp
    size_t             sz;
    logic [ADDR_W-1:0] mask;
    logic [ADDR_W-1:0] base_eff;
    logic [TOT_W-1:0]  total;
    logic              is_io;
    logic              io_big;

    always_comb begin
      sz       = size_decode(opt_i[w].size_code);
      mask     = {ADDR_W{1'b1}} << sz.lg;
      is_io    = (opt_i[w].space == SPC_IO);
      base_eff = is_io ? base_i[w][ADDR_W-1:0] : (base_i[w][ADDR_W-1:0] & PAGE_MASK);
      io_big   = is_io && (sz.lg > 5'(IO_MAX_LG));
      total    = TOT_W'(opt_i[w].setup) + TOT_W'(opt_i[w].strobe) + TOT_W'(opt_i[w].hold);
      hit_vec[w] = opt_i[w].valid && sz.ok && !io_big && (total < TOT_W'(BUS_LIMIT)) &&
                   ((addr_i & mask) == (base_eff & mask));
      off_vec[w] = addr_i & ~mask;
    end
  end

  // lowest index wins
  always_comb begin
    idx_o = '0;
    for (int i = N_WIN - 1; i >= 0; i--) begin
      if (hit_vec[i]) idx_o = WIN_W'(i);
    end
  end

  assign hit_o   = |hit_vec;
  assign wp_o    = opt_i[idx_o].wp;
  assign sock_o  = opt_i[idx_o].sock;
  assign space_o = opt_i[idx_o].space;
  assign wide_o  = opt_i[idx_o].wide;
  assign su_o    = opt_i[idx_o].setup;
  assign st_o    = opt_i[idx_o].strobe;
  assign ho_o    = opt_i[idx_o].hold;
  assign off_o   = off_vec[idx_o];

endmodule

// File: rtl/cwin_seq.sv
module cwin_seq
  import cwin_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [SU_W-1:0]  su_i,
  input  logic [STB_W-1:0] st_i,
  input  logic [HO_W-1:0]  ho_i,
  output logic             setup_o,
  output logic             strobe_o,
  output logic             hold_o,
  output logic             busy_o,
  output logic             done_o
);

  localparam int CNT_W = (STB_W > SU_W) ? ((STB_W > HO_W) ? STB_W : HO_W)
                                        : ((SU_W > HO_W) ? SU_W : HO_W);

  phase_e           ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [SU_W-1:0]  su_q, su_s;
  logic [STB_W-1:0] st_q, st_s;
  logic [HO_W-1:0]  ho_q, ho_s;
  logic             done_q, done_d;
  logic             adv;

  // counts come from the request while idle, from the latch afterwards
  assign su_s = (ph_q == PH_IDLE) ? su_i : su_q;
  assign st_s = (ph_q == PH_IDLE) ? st_i : st_q;
  assign ho_s = (ph_q == PH_IDLE) ? ho_i : ho_q;

  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    adv    = 1'b0;
    if (ph_q == PH_IDLE) adv = start_i;
    else if (cnt_q == '0) adv = 1'b1;
    else cnt_d = cnt_q - CNT_W'(1);
    if (adv) begin
      if (ph_q == PH_IDLE && su_s != '0) begin
        ph_d  = PH_SETUP;
        cnt_d = CNT_W'(su_s) - CNT_W'(1);
      end else if (ph_q < PH_STROBE && st_s != '0) begin
        ph_d  = PH_STROBE;
        cnt_d = CNT_W'(st_s) - CNT_W'(1);
      end else if (ph_q != PH_HOLD && ho_s != '0) begin
        ph_d  = PH_HOLD;
        cnt_d = CNT_W'(ho_s) - CNT_W'(1);
      end else begin
        ph_d   = PH_IDLE;
        cnt_d  = '0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
      su_q   <= '0;
      st_q   <= '0;
      ho_q   <= '0;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
      if (ph_q == PH_IDLE && start_i) begin
        su_q <= su_i;
        st_q <= st_i;
        ho_q <= ho_i;
      end
    end
  end

  assign setup_o  = (ph_q == PH_SETUP);
  assign strobe_o = (ph_q == PH_STROBE);
  assign hold_o   = (ph_q == PH_HOLD);
  assign busy_o   = (ph_q != PH_IDLE);
  assign done_o   = done_q;

endmodule

// File: rtl/cwin_decoder.sv
module cwin_decoder
  import cwin_pkg::*;
#(
  parameter int N_WIN     = 8,
  parameter int ADDR_W    = 32,
  parameter int BUS_LIMIT = 60,
  parameter int IO_MAX_LG = 16,
  localparam int IDX_W    = $clog2(2 * N_WIN),
  localparam int WIN_W    = $clog2(N_WIN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [IDX_W-1:0]  cfg_addr_i,
  input  logic [31:0]       cfg_wdata_i,
  output logic [31:0]       cfg_rdata_o,
  input  logic              req_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              busy_o,
  output logic [WIN_W-1:0]  win_o,
  output logic              sock_o,
  output logic [1:0]        space_o,
  output logic              wide_o,
  output logic [ADDR_W-1:0] card_off_o,
  output logic              setup_o,
  output logic              strobe_o,
  output logic              hold_o,
  output logic              done_o,
  output logic              wp_err_o
);

  logic [N_WIN-1:0][31:0] base_w;
  opt_t [N_WIN-1:0]       opt_w;

  logic              m_hit, m_wp, m_sock, m_wide;
  logic [WIN_W-1:0]  m_idx;
  space_e            m_space;
  logic [SU_W-1:0]   m_su;
  logic [STB_W-1:0]  m_st;
  logic [HO_W-1:0]   m_ho;
  logic [ADDR_W-1:0] m_off;

  logic seq_busy, take, start;
  logic wp_err_q;

  logic [WIN_W-1:0]  win_q;
  logic              sock_q, wide_q;
  space_e            space_q;
  logic [ADDR_W-1:0] off_q;

  cwin_regs #(.N_WIN(N_WIN), .IDX_W(IDX_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .addr_i  (cfg_addr_i),
    .wdata_i (cfg_wdata_i),
    .rdata_o (cfg_rdata_o),
    .base_o  (base_w),
    .opt_o   (opt_w)
  );

  cwin_match #(
    .N_WIN(N_WIN), .ADDR_W(ADDR_W), .BUS_LIMIT(BUS_LIMIT),
    .IO_MAX_LG(IO_MAX_LG), .WIN_W(WIN_W)
  ) u_match (
    .addr_i  (req_addr_i),
    .base_i  (base_w),
    .opt_i   (opt_w),
    .hit_o   (m_hit),
    .idx_o   (m_idx),
    .wp_o    (m_wp),
    .sock_o  (m_sock),
    .space_o (m_space),
    .wide_o  (m_wide),
    .su_o    (m_su),
    .st_o    (m_st),
    .ho_o    (m_ho),
    .off_o   (m_off)
  );

  assign take  = req_i && !seq_busy && m_hit;
  assign start = take && !(req_write_i && m_wp);

  cwin_seq u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .su_i     (m_su),
    .st_i     (m_st),
    .ho_i     (m_ho),
    .setup_o  (setup_o),
    .strobe_o (strobe_o),
    .hold_o   (hold_o),
    .busy_o   (seq_busy),
    .done_o   (done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_err_q <= 1'b0;
      win_q    <= '0;
      sock_q   <= 1'b0;
      wide_q   <= 1'b0;
      space_q  <= SPC_COMMON;
      off_q    <= '0;
    end else begin
      wp_err_q <= take && req_write_i && m_wp;
      if (start) begin
        win_q   <= m_idx;
        sock_q  <= m_sock;
        wide_q  <= m_wide;
        space_q <= m_space;
        off_q   <= m_off;
      end
    end
  end

  assign busy_o     = seq_busy;
  assign wp_err_o   = wp_err_q;
  assign win_o      = win_q;
  assign sock_o     = sock_q;
  assign wide_o     = wide_q;
  assign space_o    = space_q;
  assign card_off_o = off_q;

endmodule

// File: rtl/cwin_decoder_chk.sv
module cwin_decoder_chk #(
  parameter int BUS_LIMIT = 60,
  parameter int ADDR_W    = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              setup_o,
  input logic              strobe_o,
  input logic              hold_o,
  input logic              done_o,
  input logic              wp_err_o,
  input logic              sock_o,
  input logic [ADDR_W-1:0] card_off_o
);

  localparam int CW = $clog2(BUS_LIMIT + 1);

  logic [CW-1:0] busy_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_cnt_q <= '0;
    else if (busy_o) busy_cnt_q <= busy_cnt_q + CW'(1);
    else             busy_cnt_q <= '0;
  end

  assert_one_phase_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({setup_o, strobe_o, hold_o}));

  assert_done_at_end_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  assert_wp_no_strobe_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wp_err_o |-> !(setup_o || strobe_o || hold_o || done_o));

  assert_attr_stable_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(card_off_o) && $stable(sock_o)));

  assert_bus_limit_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (busy_cnt_q < CW'(BUS_LIMIT - 1)));

endmodule

bind cwin_decoder cwin_decoder_chk #(.BUS_LIMIT(BUS_LIMIT), .ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy_o     (busy_o),
  .setup_o    (setup_o),
  .strobe_o   (strobe_o),
  .hold_o     (hold_o),
  .done_o     (done_o),
  .wp_err_o   (wp_err_o),
  .sock_o     (sock_o),
  .card_off_o (card_off_o)
);

// File: tb/cwin_decoder_tb.sv
`timescale 1ns/1ps
module cwin_decoder_tb;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [3:0]  cfg_addr_i = '0;
  logic [31:0] cfg_wdata_i = '0;
  logic [31:0] cfg_rdata_o;
  logic        req_i = 1'b0;
  logic        req_write_i = 1'b0;
  logic [31:0] req_addr_i = '0;
  logic        busy_o, sock_o, wide_o, setup_o, strobe_o, hold_o, done_o, wp_err_o;
  logic [2:0]  win_o;
  logic [1:0]  space_o;
  logic [31:0] card_off_o;

  always #2.5 clk_i = ~clk_i;

  cwin_decoder u_dut (.*);

  int total = 0;
  int bad = 0;
  bit chk_en = 0;
  logic [31:0] bbase [8];
  logic [31:0] bopt [8];
  localparam logic [31:0] IMPL = 32'hF80F_FFDF;

  // reference model state
  int m_ph = 0, m_rem = 0, m_su = 0, m_st = 0, m_ho = 0, m_win = 0, m_space = 0;
  bit m_done = 0, m_err = 0, m_sock = 0, m_wide = 0;
  longint unsigned m_off = 0;

  task automatic chk(string tag, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int lg_of(logic [4:0] c);
    case (c)
      0: return 0;   1: return 1;   2: return 3;   3: return 2;
      4: return 7;   5: return 6;   6: return 4;   7: return 5;
      8: return 15;  9: return 14;  10: return 12; 11: return 13;
      12: return 8;  13: return 9;  14: return 11; 15: return 10;
      20: return 24; 21: return 25; 23: return 26;
      24: return 16; 25: return 17; 26: return 19; 27: return 18;
      28: return 23; 29: return 22; 30: return 20; 31: return 21;
      default: return -1;
    endcase
  endfunction

  function automatic logic [31:0] mk(int code, int su, int st, int ho, int wide,
                                     int space, int sock, int wp, int valid);
    return (32'(code) << 27) | (32'(ho) << 16) | (32'(su) << 12) | (32'(st) << 7) |
           (32'(wide) << 6) | (32'(space) << 3) | (32'(sock) << 2) | (32'(wp) << 1) |
           32'(valid);
  endfunction

  function automatic int find_win(logic [31:0] a, output longint unsigned off);
    off = 0;
    for (int w = 0; w < 8; w++) begin
      logic [31:0] o;
      int lg, sp, tot;
      longint unsigned sz, b;
      o = bopt[w];
      lg = lg_of(o[31:27]);
      sp = int'(o[4:3]);
      tot = int'(o[15:12]) + int'(o[11:7]) + int'(o[19:16]);
      if (o[0] && lg >= 0 && !(sp == 3 && lg > 16) && tot < 60) begin
        sz = longint'(1) << lg;
        b = (sp == 3) ? bbase[w] : (bbase[w] & 32'hFFFF_F000);
        if ((longint'(a) / sz) == (b / sz)) begin
          off = longint'(a) % sz;
          return w;
        end
      end
    end
    return -1;
  endfunction

  function automatic void advance(int from);
    if (from < 1 && m_su > 0) begin m_ph = 1; m_rem = m_su; end
    else if (from < 2 && m_st > 0) begin m_ph = 2; m_rem = m_st; end
    else if (from < 3 && m_ho > 0) begin m_ph = 3; m_rem = m_ho; end
    else begin m_ph = 0; m_done = 1; end
  endfunction

  always @(posedge clk_i) begin
    if (rst_ni) begin
      m_done = 0;
      m_err = 0;
      if (m_ph != 0) begin
        m_rem--;
        if (m_rem == 0) advance(m_ph);
      end else if (req_i) begin
        longint unsigned off;
        int w;
        w = find_win(req_addr_i, off);
        if (w >= 0) begin
          if (req_write_i && bopt[w][1]) m_err = 1;
          else begin
            m_win = w; m_off = off;
            m_sock = bopt[w][2]; m_space = int'(bopt[w][4:3]); m_wide = bopt[w][6];
            m_su = int'(bopt[w][15:12]); m_st = int'(bopt[w][11:7]); m_ho = int'(bopt[w][19:16]);
            advance(0);
          end
        end
      end
    end
  end

  always @(negedge clk_i) begin
    if (chk_en) begin
      chk("R8 busy", busy_o, m_ph != 0);
      chk("R8 setup", setup_o, m_ph == 1);
      chk("R8 strobe", strobe_o, m_ph == 2);
      chk("R8 hold", hold_o, m_ph == 3);
      chk("R8 done", done_o, m_done);
      chk("R10 wp_err", wp_err_o, m_err);
      if (m_ph != 0) begin
        chk("R12 win", win_o, m_win);
        chk("R12 sock", sock_o, m_sock);
        chk("R12 space", space_o, m_space);
        chk("R12 wide", wide_o, m_wide);
        chk("R4 offset", card_off_o, m_off);
      end
    end
  end

  task automatic wr(int idx, logic [31:0] d);
    @(negedge clk_i);
    cfg_we_i = 1; cfg_addr_i = 4'(idx); cfg_wdata_i = d;
    @(posedge clk_i);
    if (idx % 2 == 1) bopt[idx/2] = d; else bbase[idx/2] = d;
    @(negedge clk_i);
    cfg_we_i = 0;
  endtask

  task automatic rd(int idx, logic [31:0] exp, string tag);
    @(negedge clk_i);
    cfg_addr_i = 4'(idx);
    #1 chk(tag, cfg_rdata_o, exp);
  endtask

  task automatic issue(logic [31:0] a, bit w, bit exp_act, int exp_win, string tag);
    @(negedge clk_i);
    req_i = 1; req_addr_i = a; req_write_i = w;
    @(negedge clk_i);
    req_i = 0;
    chk(tag, busy_o | done_o, exp_act);
    if (exp_win >= 0 && busy_o) chk({tag, " window"}, win_o, exp_win);
    for (int i = 0; i < 80 && busy_o; i++) @(negedge clk_i);
    @(negedge clk_i);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin bbase[i] = 0; bopt[i] = 0; end
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    // R1 reset state
    for (int i = 0; i < 16; i++) rd(i, 32'h0, "R1 reset register");
    chk("R1 busy", busy_o, 0);
    chk("R1 phases", {setup_o, strobe_o, hold_o, done_o, wp_err_o}, 0);
    chk_en = 1;

    wr(0,  32'h0061_0000); wr(1,  mk(24, 2, 3, 1, 0, 0, 0, 0, 1));
    wr(2,  32'h0000_0300); wr(3,  mk(2, 0, 2, 0, 1, 3, 1, 0, 1));
    wr(4,  32'h0100_0000); wr(5,  mk(20, 1, 1, 1, 0, 2, 0, 1, 1));
    wr(6,  32'h0060_0000); wr(7,  mk(25, 1, 1, 1, 0, 0, 0, 0, 1));
    wr(8,  32'h0200_0000); wr(9,  mk(17, 1, 1, 1, 0, 0, 0, 0, 1));
    wr(10, 32'h0300_0000); wr(11, mk(24, 15, 31, 15, 0, 0, 1, 0, 1));
    wr(12, 32'h0400_0000); wr(13, mk(25, 1, 2, 1, 0, 3, 1, 0, 1));
    wr(14, 32'h0500_0ABC); wr(15, mk(0, 0, 0, 0, 0, 0, 0, 0, 1) | 32'h0040_0020);

    // R2 register map and reserved bits
    rd(6, 32'h0060_0000, "R2 base word");
    rd(3, mk(2, 0, 2, 0, 1, 3, 1, 0, 1), "R2 option word");
    rd(15, bopt[7] & IMPL, "R2 reserved bits read zero");

    issue(32'h0061_0010, 0, 1, 0, "R5 lowest window wins");
    issue(32'h0060_0020, 0, 1, 3, "R4 single hit");
    issue(32'h0000_0305, 1, 1, 1, "R3 8-byte io hit");
    issue(32'h0000_0308, 0, 0, -1, "R3 8-byte io miss");
    issue(32'h0123_4567, 1, 0, -1, "R10 protected write refused");
    issue(32'h0123_4567, 0, 1, 2, "R10 protected read allowed");
    issue(32'h0200_0000, 0, 0, -1, "R3 reserved code");
    issue(32'h0300_0000, 0, 0, -1, "R11 total 61 rejected");
    issue(32'h0400_0000, 0, 0, -1, "R7 io over 64K rejected");
    issue(32'h0500_0ABC, 0, 0, -1, "R6 base low bits ignored");
    issue(32'h0500_0000, 0, 1, -1, "R9 zero-length access");
    issue(32'h0F00_0000, 0, 0, -1, "R13 no window");

    wr(11, mk(24, 15, 31, 13, 0, 0, 1, 0, 1));
    issue(32'h0300_1234, 0, 1, 5, "R11 total 59 accepted");
    wr(13, mk(24, 1, 2, 1, 0, 3, 1, 0, 1));
    issue(32'h0400_ABCD, 1, 1, 6, "R7 io 64K accepted");
    wr(5, mk(20, 1, 1, 1, 0, 2, 0, 1, 0));
    issue(32'h0123_4567, 0, 0, -1, "R4 invalid window");

    // R12 request while busy is dropped
    @(negedge clk_i);
    req_i = 1; req_addr_i = 32'h0061_0004; req_write_i = 0;
    @(negedge clk_i);
    req_addr_i = 32'h0000_0301;
    @(negedge clk_i);
    req_i = 0;
    for (int i = 0; i < 80 && busy_o; i++) @(negedge clk_i);
    @(negedge clk_i);
    chk("R12 busy request dropped", busy_o | done_o, 0);

    repeat (3) @(negedge clk_i);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule